// File: doc/BRIEF.md
# Activity-Triggered Array Power Gate

This block decides, cycle by cycle, whether a static memory array should be powered. It samples the array's control, address and data inputs on every clock and compares each sample with the value captured on the clock before. A qualifying transition counts as a wake event. A wake event turns the power flag on and loads a hold-off counter with its full interval.

When the counter runs out with no further event, the flag drops. It drops even if the chip stays selected. Power therefore follows the rate of memory cycles, not the length of time the select line is held low. Holding the array's clear input low is also a wake event. The array stays powered while a clear is in progress and then shuts down one interval after the clear is released.

Top module: `act_power_gate`

## Requirements
- R1: After `rst_n` is released, `pwr_on` is 0. It stays 0 while `sel_n` stays high and `clr_n` stays high, whatever `addr`, `data` and `wr_n` do.
- R2: A falling edge of `sel_n` (high on one sample, low on the next) sets `pwr_on` to 1 from the cycle after the sampling edge. A rising edge of `sel_n` is not a wake event.
- R3: A falling edge of `wr_n` is a wake event only if `sel_n` is low on the same sample that sees `wr_n` low.
- R4: A change on any single bit of `addr` between two samples is a wake event only if `sel_n` is low on the later sample.
- R5: A change on any single bit of `data` between two samples is a wake event only if both `sel_n` and `wr_n` are low on the later sample.
- R6: After the last wake event, `pwr_on` stays 1 for exactly `HOLD` clock cycles and then returns to 0, even if `sel_n` is held low and steady.
- R7: A wake event that arrives while the counter is still running reloads it to the full `HOLD`. The flag then stays 1 for `HOLD` cycles counted from the new event.
- R8: Every sample with `clr_n` low is a wake event. `pwr_on` falls `HOLD` cycles after the last sample on which `clr_n` was low.
- R9: Every combination of previous and current `sel_n`/`wr_n` levels, with or without an address or data change, gives a wake event exactly when one of the rules in R2 to R5 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of this controller |
| sel_n | input | 1 | Active-low array select |
| wr_n | input | 1 | Active-low array write strobe |
| addr | input | AW | Array address bus |
| data | input | DW | Array data bus |
| clr_n | input | 1 | Active-low array clear request |
| pwr_on | output | 1 | 1 while the array should be powered |

## Verification
The bench goes after the qualification rules. If a gate is missing, a toggle on the write strobe, the address or the data while the array is deselected would raise the flag. If a gate is too strict, a genuine data write would leave the array asleep. It measures how long the flag stays high after each event, so an off-by-one in the counter shows as a hold of `HOLD` plus or minus one. A design that does not reload would also drop too early after a second event. Each address and data bit is toggled on its own, which exposes a comparator that ignores some bits. A swept table over all previous and current select and strobe levels catches designs that fire on rising edges.

// File: rtl/act_power_gate.sv
module act_power_gate #(
  parameter int AW   = 13,
  parameter int DW   = 8,
  parameter int HOLD = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          clr_n,
  output logic          pwr_on
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD);

  logic          sel_q, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt;

  wire ev_sel  = sel_q & ~sel_n;
  wire ev_wr   = wr_q & ~wr_n & ~sel_n;
  wire ev_addr = (addr != addr_q) & ~sel_n;
  wire ev_data = (data != data_q) & ~sel_n & ~wr_n;
  wire ev_clr  = ~clr_n;
  wire wake    = ev_sel | ev_wr | ev_addr | ev_data | ev_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      wr_q   <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
      cnt    <= '0;
    end else begin
      sel_q  <= sel_n;
      wr_q   <= wr_n;
      addr_q <= addr;
      data_q <= data;
      if (wake)            cnt <= FULL;
      else if (cnt != '0)  cnt <= cnt - CW'(1);
    end
  end

  assign pwr_on = (cnt != '0);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on && !wake) |=> !pwr_on);
  p_sel_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !sel_n) |=> pwr_on);
  p_wr_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_n && !sel_n) |=> pwr_on);
  p_addr_chg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && addr != addr_q) |=> pwr_on);
  p_data_chg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_n && data != data_q) |=> pwr_on);
  p_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(1) && !wake) |=> !pwr_on);
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (cnt == FULL));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> pwr_on);
endmodule

// File: tb/test_act_power_gate.sv
module test_act_power_gate;
  localparam int AW = 4, DW = 3, HOLD = 4;

  logic clk = 0, rst_n = 0, sel_n = 1, wr_n = 1, clr_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic pwr_on;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  act_power_gate #(.AW(AW), .DW(DW), .HOLD(HOLD)) i_act_power_gate (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
    .addr(addr), .data(data), .clr_n(clr_n), .pwr_on(pwr_on));

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  function automatic int dummy(); return 0; endfunction

  task automatic measure(output int n);
    n = 0;
    while (pwr_on && n < 40) begin n++; tick(); end
  endtask

  task automatic settle();
    int n;
    measure(n);
  endtask

  initial begin
    int n;
    repeat (3) tick();
    chk("R1 during reset", pwr_on, 0);
    rst_n = 1;
    tick();
    chk("R1 after reset", pwr_on, 0);
    for (int i = 0; i < 12; i++) begin
      addr = addr + 1; data = data ^ 3'b101; wr_n = ~wr_n;
      tick();
      chk("R1 idle activity while deselected", pwr_on, 0);
    end
    wr_n = 1; tick(); settle();

    sel_n = 0; tick();
    chk("R2 select fall wakes", pwr_on, 1);
    measure(n);
    chk("R6 hold length with select held low", n, HOLD);
    sel_n = 1; tick();
    chk("R2 select rise is not an event", pwr_on, 0);

    wr_n = 0; tick();
    chk("R3 strobe fall ignored while deselected", pwr_on, 0);
    wr_n = 1; tick();
    sel_n = 0; tick(); settle();
    wr_n = 0; tick();
    chk("R3 strobe fall wakes while selected", pwr_on, 1);
    measure(n);
    chk("R3 hold after strobe", n, HOLD);
    wr_n = 1; tick();
    chk("R3 strobe rise is not an event", pwr_on, 0);

    for (int b = 0; b < AW; b++) begin
      addr[b] = ~addr[b]; tick();
      chk($sformatf("R4 address bit %0d wakes", b), pwr_on, 1);
      measure(n);
      chk("R4 hold after address change", n, HOLD);
    end
    sel_n = 1; tick(); settle();
    for (int b = 0; b < AW; b++) begin
      addr[b] = ~addr[b]; tick();
      chk($sformatf("R4 address bit %0d ignored deselected", b), pwr_on, 0);
    end

    sel_n = 0; tick(); settle();
    for (int b = 0; b < DW; b++) begin
      data[b] = ~data[b]; tick();
      chk($sformatf("R5 data bit %0d ignored on read", b), pwr_on, 0);
    end
    wr_n = 0; tick(); settle();
    for (int b = 0; b < DW; b++) begin
      data[b] = ~data[b]; tick();
      chk($sformatf("R5 data bit %0d wakes on write", b), pwr_on, 1);
      measure(n);
      chk("R5 hold after data change", n, HOLD);
    end
    sel_n = 1; tick(); settle();
    for (int b = 0; b < DW; b++) begin
      data[b] = ~data[b]; tick();
      chk($sformatf("R5 data bit %0d ignored deselected", b), pwr_on, 0);
    end
    wr_n = 1; tick();

    sel_n = 0; tick();
    tick(); tick();
    addr = addr ^ 4'b0001; tick();
    chk("R7 second event keeps power", pwr_on, 1);
    measure(n);
    chk("R7 hold restarts at second event", n, HOLD);

    for (int k = 0; k < 3; k++) begin
      clr_n = 0; tick();
      chk("R8 clear keeps power on", pwr_on, 1);
    end
    clr_n = 1;
    measure(n);
    chk("R8 power drops after clear release", n, HOLD);
    sel_n = 1; tick(); settle();

    for (int c = 0; c < 64; c++) begin
      bit ps, pw, cs, cw, ta, td, exp;
      {ps, pw, cs, cw, ta, td} = 6'(c);
      sel_n = ps; wr_n = pw; tick(); settle();
      sel_n = cs; wr_n = cw;
      if (ta) addr = addr + 1;
      if (td) data = data + 1;
      exp = (ps & !cs) | (pw & !cw & !cs) | (ta & !cs) | (td & !cs & !cw);
      tick();
      chk($sformatf("R9 case ps%0d pw%0d cs%0d cw%0d a%0d d%0d", ps, pw, cs, cw, ta, td),
          pwr_on, exp);
      settle();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule